// File: doc/BRIEF.md
# Four-Digit Clock Display Scanner

This block time-multiplexes a four-position common-anode seven-segment display, showing a clock's time held as BCD digits. Once per scan tick it turns on the next digit position and presents that position's segment pattern. The tick is a single-cycle enable in the system clock domain, typically near 200 Hz. Only one position is lit at a time, so the same seven segment lines serve all four positions.

A view-select line picks between two rotations. The hours-minutes view cycles through all four positions. The seconds view cycles only between the two rightmost positions, showing seconds tens and seconds units. When an enable pattern does not belong to the active rotation, the next tick returns the scanner to the start of that rotation. This covers the state after reset and a change of view.

Top module: `clock_digit_scanner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `dig_en_n` = 1111 and `seg_n` = 1111111 (all digits off, all segments dark). These values hold until the first scan tick.
- R2: On a clock edge without `scan_tick`, neither `dig_en_n` nor `seg_n` changes, whatever the digit inputs or `view_hm` do.
- R3: With `view_hm` = 1, each tick moves `dig_en_n` through 0111 → 1011 → 1101 → 1110 → 0111 (active low; bit 3 is the leftmost position). At most one enable bit is ever low.
- R4: In the hours-minutes view, each pattern shows its own digit on `seg_n`, updated at the same edge as the enables: 0111 shows `hr_tens`, 1011 shows `hr_units`, 1101 shows `min_tens` and 1110 shows `min_units`.
- R5: With `view_hm` = 0, only 1101 and 1110 are used. A tick from 1110 gives 1101 showing `sec_tens`, and a tick from 1101 gives 1110 showing `sec_units`.
- R6: A tick taken from a pattern outside the active rotation gives that rotation's first step. This is 0111 with `hr_tens` in the hours-minutes view, and 1101 with `sec_tens` in the seconds view.
- R7: `seg_n` is active low, with bit 6 = segment a down to bit 0 = segment g. The digits 0–9 encode as 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000 and 0000100.
- R8: A presented BCD value from 10 to 15 gives `seg_n` = 1111111.
- R9: A change of `view_hm` alters nothing until the next tick. That tick follows the newly selected rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | One-cycle scan step enable |
| view_hm | input | 1 | 1 = hours-minutes view, 0 = seconds view |
| hr_tens | input | 4 | Hour tens BCD |
| hr_units | input | 4 | Hour units BCD |
| min_tens | input | 4 | Minute tens BCD |
| min_units | input | 4 | Minute units BCD |
| sec_tens | input | 4 | Second tens BCD |
| sec_units | input | 4 | Second units BCD |
| dig_en_n | output | 4 | Active-low digit enables, bit 3 leftmost |
| seg_n | output | 7 | Active-low segments, bit 6 = a … bit 0 = g |

## Verification
Each of the six digit inputs carries a different BCD value, offset from the others, so a segment pattern that comes from the wrong source is visible. Those offsets sweep through all sixteen codes over successive rounds, which tests every decoder entry and the blanking of codes 10–15 at every position. The two rotations are run separately. The view is then switched in the middle of a rotation, which separates the recovery step from the normal step. Holding the tick low while the inputs change shows that the outputs move only on a tick.

// File: rtl/clock_digit_scanner.sv
module clock_digit_scanner #(
  parameter int BCD_W = 4,
  parameter int SEG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic             view_hm,
  input  logic [BCD_W-1:0] hr_tens,
  input  logic [BCD_W-1:0] hr_units,
  input  logic [BCD_W-1:0] min_tens,
  input  logic [BCD_W-1:0] min_units,
  input  logic [BCD_W-1:0] sec_tens,
  input  logic [BCD_W-1:0] sec_units,
  output logic [3:0]       dig_en_n,
  output logic [SEG_W-1:0] seg_n
);

  localparam logic [3:0] POS_HT  = 4'b0111;
  localparam logic [3:0] POS_HU  = 4'b1011;
  localparam logic [3:0] POS_MT  = 4'b1101;
  localparam logic [3:0] POS_MU  = 4'b1110;
  localparam logic [3:0] ALL_OFF = 4'b1111;
  localparam logic [SEG_W-1:0] DARK = '1;

  function automatic logic [SEG_W-1:0] to_seg(input logic [BCD_W-1:0] v);
    case (v)
      4'd0:    to_seg = 7'b0000001;
      4'd1:    to_seg = 7'b1001111;
      4'd2:    to_seg = 7'b0010010;
      4'd3:    to_seg = 7'b0000110;
      4'd4:    to_seg = 7'b1001100;
      4'd5:    to_seg = 7'b0100100;
      4'd6:    to_seg = 7'b0100000;
      4'd7:    to_seg = 7'b0001111;
      4'd8:    to_seg = 7'b0000000;
      4'd9:    to_seg = 7'b0000100;
      default: to_seg = DARK;
    endcase
  endfunction

  logic [3:0]       en_q, en_d;
  logic [SEG_W-1:0] seg_q;
  logic [BCD_W-1:0] pick;

  always_comb begin
    en_d = POS_HT;
    pick = hr_tens;
    if (view_hm) begin
      case (en_q)
        POS_HT:  begin en_d = POS_HU; pick = hr_units;  end
        POS_HU:  begin en_d = POS_MT; pick = min_tens;  end
        POS_MT:  begin en_d = POS_MU; pick = min_units; end
        default: begin en_d = POS_HT; pick = hr_tens;   end
      endcase
    end else begin
      case (en_q)
        POS_MT:  begin en_d = POS_MU; pick = sec_units; end
        default: begin en_d = POS_MT; pick = sec_tens;  end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= ALL_OFF;
      seg_q <= DARK;
    end else if (scan_tick) begin
      en_q  <= en_d;
      seg_q <= to_seg(pick);
    end
  end

  assign dig_en_n = en_q;
  assign seg_n    = seg_q;

endmodule

// File: rtl/clock_digit_scanner_chk.sv
module clock_digit_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_tick,
  input logic       view_hm,
  input logic [3:0] hr_tens,
  input logic [3:0] sec_tens,
  input logic [3:0] dig_en_n,
  input logic [6:0] seg_n
);

  a_r1_reset_dark: assert property (@(posedge clk)
    (rst_n && $past(!rst_n)) |-> (dig_en_n == 4'b1111 && seg_n == 7'h7F));

  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> ($stable(dig_en_n) && $stable(seg_n)));

  a_r3_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_en_n));

  a_r3_hm_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && view_hm && dig_en_n == 4'b1110) |=> dig_en_n == 4'b0111);

  a_r5_sec_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && !view_hm) |=> (dig_en_n == 4'b1110 || dig_en_n == 4'b1101));

  a_r6_sec_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && !view_hm && dig_en_n != 4'b1101 && dig_en_n != 4'b1110)
      |=> dig_en_n == 4'b1101);

  a_r8_blank_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && view_hm && dig_en_n == 4'b1110 && hr_tens > 4'd9)
      |=> seg_n == 7'h7F);

  a_r8_blank_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && !view_hm && dig_en_n == 4'b1110 && sec_tens > 4'd9)
      |=> seg_n == 7'h7F);

endmodule

bind clock_digit_scanner clock_digit_scanner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .view_hm(view_hm),
  .hr_tens(hr_tens), .sec_tens(sec_tens), .dig_en_n(dig_en_n), .seg_n(seg_n)
);

// File: tb/tb_clock_digit_scanner.sv
module tb_clock_digit_scanner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_tick = 1'b0;
  logic view_hm = 1'b1;
  logic [3:0] ht = 0, hu = 0, mt = 0, mu = 0, st = 0, su = 0;
  logic [3:0] dig_en_n;
  logic [6:0] seg_n;
  int total = 0, bad = 0;
  logic [3:0] exp_en;

  always #4 clk = ~clk;

  clock_digit_scanner dut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .view_hm(view_hm),
    .hr_tens(ht), .hr_units(hu), .min_tens(mt), .min_units(mu),
    .sec_tens(st), .sec_units(su), .dig_en_n(dig_en_n), .seg_n(seg_n)
  );

  function automatic logic [6:0] enc(input logic [3:0] v);
    logic [6:0] t [10] = '{7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110,
                           7'b1001100, 7'b0100100, 7'b0100000, 7'b0001111,
                           7'b0000000, 7'b0000100};
    return (v > 9) ? 7'b1111111 : t[v];
  endfunction

  task automatic check(input bit ok, input string req, input logic [10:0] act,
                       input logic [10:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick_and_check(input string req);
    logic [3:0] d;
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    if (view_hm)
      case (exp_en)
        4'b0111: begin exp_en = 4'b1011; d = hu; end
        4'b1011: begin exp_en = 4'b1101; d = mt; end
        4'b1101: begin exp_en = 4'b1110; d = mu; end
        default: begin exp_en = 4'b0111; d = ht; end
      endcase
    else
      case (exp_en)
        4'b1110: begin exp_en = 4'b1101; d = st; end
        4'b1101: begin exp_en = 4'b1110; d = su; end
        default: begin exp_en = 4'b1101; d = st; end
      endcase
    check(dig_en_n == exp_en && seg_n == enc(d), req,
          {dig_en_n, seg_n}, {exp_en, enc(d)});
  endtask

  task automatic load(input int s);
    ht = 4'(s); hu = 4'(s + 3); mt = 4'(s + 6);
    mu = 4'(s + 9); st = 4'(s + 11); su = 4'(s + 14);
  endtask

  initial begin
    logic [10:0] snap;
    repeat (3) @(negedge clk);
    check(dig_en_n == 4'hF && seg_n == 7'h7F, "R1 reset",
          {dig_en_n, seg_n}, 11'h7FF);
    rst_n = 1'b1;
    exp_en = 4'hF;
    repeat (2) @(negedge clk);
    check(dig_en_n == 4'hF && seg_n == 7'h7F, "R1 hold until tick",
          {dig_en_n, seg_n}, 11'h7FF);

    view_hm = 1'b1;
    tick_and_check("R6 recover from all-off");
    for (int s = 0; s < 16; s++) begin
      load(s);
      for (int k = 0; k < 4; k++) tick_and_check("R3 R4 R7 R8 hm sweep");
    end

    // R2: inputs and view change with no tick
    snap = {dig_en_n, seg_n};
    load(5); view_hm = 1'b0;
    repeat (4) @(negedge clk);
    check({dig_en_n, seg_n} == snap, "R2 R9 no tick, no change",
          {dig_en_n, seg_n}, snap);

    // R9: next tick follows the seconds rotation
    tick_and_check("R9 R6 view switch to seconds");
    for (int s = 0; s < 16; s++) begin
      load(s);
      for (int k = 0; k < 2; k++) tick_and_check("R5 R7 R8 sec sweep");
    end

    // R6: seconds view from an hours-minutes-only pattern
    view_hm = 1'b1;
    while (exp_en != 4'b1011) tick_and_check("R3 walk");
    view_hm = 1'b0;
    tick_and_check("R6 sec recover from 1011");
    view_hm = 1'b1;
    tick_and_check("R9 switch back to hm from 1101");
    tick_and_check("R3 continue after switch");

    // R1: reset in the middle of a scan
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    exp_en = 4'hF;
    check(dig_en_n == 4'hF && seg_n == 7'h7F, "R1 mid-run reset",
          {dig_en_n, seg_n}, 11'h7FF);
    tick_and_check("R6 after mid-run reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule